// File: doc/BRIEF.md
# Privileged Special-Register Access Gate

This block sits between a processor's move-to-special-register and move-from-special-register operations and the registers those operations reach. Each request carries a direction, an address and write data. The block checks whether the current privilege state allows the access. It then classifies the address against a fixed set of named registers and a 512-entry shadow general-register window. It returns read data at once, raises a write enable for the one register that is written, and issues side-effect strobes for the status and next-PC registers. Any access it refuses is reported on a warning output, one cycle later.

The registers that can be read and the registers that can be written are not the same set. The named registers live outside the block: their current values come in on input ports and their write enables go out on output ports. The shadow window is stored inside the block. The block accepts a request in every cycle. `req_ready` is tied high, so a request is taken in any cycle where `req_valid` is high and the requester never has to hold it.

Top module: `spr_access_gate`

## Requirements
- R1: A valid request is allowed only if `sup_mode` or `user_sr_rd` is 1. When both are 0, read data is 0, no write enable or strobe is raised and nothing is stored. In the next cycle `warn` pulses with `warn_code` 1.
- R2: An address at or above 0x10000 (the implemented count), or one that matches no named register and lies outside the window 0x0400 to 0x05FF, is invalid. A read returns 0, a write changes nothing, and `warn_code` 2 is reported.
- R3: Reads of the version (0x0000), unit-present (0x0001), CPU-config (0x0002), status (0x0011), previous-PC (0x0012), FPU control (0x0014), exception PC (0x0020), MAC low (0x2801) and MAC high (0x2802) registers return the matching input value in the same cycle. A read of a write-only address such as exception status (0x0040) returns 0 and reports `warn_code` 2.
- R4: Writes to FPU control, exception PC, exception status (0x0040), MAC low and MAC high raise only that register's enable, with `wr_data` equal to the request data. A write to a read-only register raises no enable and reports `warn_code` 2.
- R5: A write to window address 0x0400+i stores the data at the clock edge of the request. A later read of the same address returns that data combinationally.
- R6: A write to status (0x0011) raises `we_status`. `status_wval` carries the data with bit 15 (the fixed-one bit) forced to 1.
- R7: A write to next-PC (0x0010) stores nothing. It pulses `pc_redirect` and `clear_delay` for that cycle, with `redirect_pc` equal to the written value.
- R8: A write to timer mode (0x5000) is accepted with no warning when the data is 0. Nonzero data reports `warn_code` 3. In neither case is anything stored or enabled.
- R9: `warn` is a one-cycle pulse in the cycle after the offending request. It carries that request's address on `warn_addr` and the code on `warn_code`. A cycle with `req_valid` low has no effect and no warning.
- R10: After reset `warn` is 0 and every window entry reads 0.
- R11: `user_sr_rd` alone allows reads and writes in the same way as `sup_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always 1; no back-pressure |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_addr | input | 17 | Special-register address |
| req_wdata | input | 32 | Write data |
| sup_mode | input | 1 | Status: supervisor mode |
| user_sr_rd | input | 1 | Status: user access to special registers allowed |
| rd_data | output | 32 | Read data, combinational from the request |
| ver_val | input | 32 | Version register value |
| unit_val | input | 32 | Unit-present register value |
| cfg_val | input | 32 | CPU-config register value |
| stat_val | input | 32 | Status register value |
| prevpc_val | input | 32 | Previous-PC value |
| fpu_val | input | 32 | FPU control/status value |
| excpc_val | input | 32 | Exception PC value |
| maclo_val | input | 32 | MAC low value |
| machi_val | input | 32 | MAC high value |
| wr_data | output | 32 | Data for the named-register write enables |
| we_fpu | output | 1 | FPU control/status write enable |
| we_excpc | output | 1 | Exception PC write enable |
| we_excstat | output | 1 | Exception status write enable |
| we_maclo | output | 1 | MAC low write enable |
| we_machi | output | 1 | MAC high write enable |
| we_status | output | 1 | Status write enable |
| status_wval | output | 32 | Status write value with the fixed-one bit forced |
| pc_redirect | output | 1 | Next-PC write strobe |
| redirect_pc | output | 32 | Redirect target |
| clear_delay | output | 1 | Clear pending delay-slot state |
| warn | output | 1 | Refused-access pulse |
| warn_addr | output | 17 | Address of the refused access |
| warn_code | output | 2 | 1 privilege, 2 address, 3 value |

## Verification
The bench aims at the asymmetric sets. It reads a write-only register and writes a read-only one. A design that treated the two sets as one would return data or raise an enable where it must warn. It then writes the window without privilege and reads the entry back with privilege, which exposes a gate that blocks only the read path and lets the write through. The bench also probes the exact boundaries (0x10000, 0x1FFFF, the entry just past the window) and both timer-mode values. It checks that the warning drops after one cycle and that a request with `req_valid` low leaves the window untouched. A decoder with an off-by-one or a warning that latches would fail these checks.

// File: rtl/sprg_pkg.sv
package sprg_pkg;

  typedef enum logic [3:0] {
    ID_VER, ID_UNIT, ID_CFG, ID_NEXTPC, ID_STAT, ID_PREVPC, ID_FPU,
    ID_EXCPC, ID_EXCSTAT, ID_MACLO, ID_MACHI, ID_TMODE, ID_WIN, ID_NONE
  } reg_id_e;

  typedef enum logic [1:0] {
    WC_NONE  = 2'd0,
    WC_PRIV  = 2'd1,
    WC_ADDR  = 2'd2,
    WC_VALUE = 2'd3
  } warn_code_e;

  // named register addresses
  localparam int unsigned A_VER     = 'h0000;
  localparam int unsigned A_UNIT    = 'h0001;
  localparam int unsigned A_CFG     = 'h0002;
  localparam int unsigned A_NEXTPC  = 'h0010;
  localparam int unsigned A_STAT    = 'h0011;
  localparam int unsigned A_PREVPC  = 'h0012;
  localparam int unsigned A_FPU     = 'h0014;
  localparam int unsigned A_EXCPC   = 'h0020;
  localparam int unsigned A_EXCSTAT = 'h0040;
  localparam int unsigned A_MACLO   = 'h2801;
  localparam int unsigned A_MACHI   = 'h2802;
  localparam int unsigned A_TMODE   = 'h5000;

  function automatic logic id_readable(reg_id_e id);
    case (id)
      ID_VER, ID_UNIT, ID_CFG, ID_STAT, ID_PREVPC, ID_FPU,
      ID_EXCPC, ID_MACLO, ID_MACHI, ID_WIN: return 1'b1;
      default:                              return 1'b0;
    endcase
  endfunction

  function automatic logic id_writable(reg_id_e id);
    case (id)
      ID_FPU, ID_EXCPC, ID_EXCSTAT, ID_MACLO, ID_MACHI,
      ID_STAT, ID_NEXTPC, ID_TMODE, ID_WIN: return 1'b1;
      default:                              return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sprg_decode.sv
module sprg_decode
  import sprg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned WIN_BASE  = 'h0400,
  parameter int unsigned WIN_DEPTH = 512,
  parameter int unsigned REG_COUNT = 'h10000,
  parameter int unsigned IDX_W     = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_id_e           id,
  output logic [IDX_W-1:0]  win_idx
);

  logic [ADDR_W-1:0] off;
  logic              in_range;
  logic              in_win;

  always_comb begin
    off      = addr - ADDR_W'(WIN_BASE);
    in_range = 32'(addr) < REG_COUNT;
    in_win   = (32'(addr) >= WIN_BASE) && (32'(off) < WIN_DEPTH);
    win_idx  = off[IDX_W-1:0];
    id       = ID_NONE;
    if (in_range) begin
      case (addr)
        ADDR_W'(A_VER):     id = ID_VER;
        ADDR_W'(A_UNIT):    id = ID_UNIT;
        ADDR_W'(A_CFG):     id = ID_CFG;
        ADDR_W'(A_NEXTPC):  id = ID_NEXTPC;
        ADDR_W'(A_STAT):    id = ID_STAT;
        ADDR_W'(A_PREVPC):  id = ID_PREVPC;
        ADDR_W'(A_FPU):     id = ID_FPU;
        ADDR_W'(A_EXCPC):   id = ID_EXCPC;
        ADDR_W'(A_EXCSTAT): id = ID_EXCSTAT;
        ADDR_W'(A_MACLO):   id = ID_MACLO;
        ADDR_W'(A_MACHI):   id = ID_MACHI;
        ADDR_W'(A_TMODE):   id = ID_TMODE;
        default:            id = in_win ? ID_WIN : ID_NONE;
      endcase
    end
  end

endmodule

// File: rtl/sprg_window.sv
module sprg_window #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 512,
  parameter int unsigned IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[idx] <= wr_data;
    end
  end

  assign rd_data = mem[idx];

  AST_WIN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $stable(idx)) |=> (rd_data == $past(wr_data))) // R5
    else $error("window write not visible");

endmodule

// File: rtl/sprg_warn.sv
module sprg_warn
  import sprg_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  warn_code_e        code_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              warn,
  output logic [ADDR_W-1:0] warn_addr,
  output logic [1:0]        warn_code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn      <= 1'b0;
      warn_addr <= '0;
      warn_code <= 2'd0;
    end else begin
      warn      <= (code_in != WC_NONE);
      warn_addr <= addr_in;
      warn_code <= code_in;
    end
  end

  AST_WARN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (code_in != WC_NONE) |=> (warn && warn_addr == $past(addr_in))) // R9
    else $error("warning missing");

  AST_WARN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (code_in == WC_NONE) |=> !warn) // R9
    else $error("warning held");

endmodule

// File: rtl/spr_access_gate.sv
module spr_access_gate
  import sprg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned DW        = 32,
  parameter int unsigned WIN_BASE  = 'h0400,
  parameter int unsigned WIN_DEPTH = 512,
  parameter int unsigned REG_COUNT = 'h10000,
  parameter int unsigned FO_BIT    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic              sup_mode,
  input  logic              user_sr_rd,
  output logic [DW-1:0]     rd_data,
  input  logic [DW-1:0]     ver_val,
  input  logic [DW-1:0]     unit_val,
  input  logic [DW-1:0]     cfg_val,
  input  logic [DW-1:0]     stat_val,
  input  logic [DW-1:0]     prevpc_val,
  input  logic [DW-1:0]     fpu_val,
  input  logic [DW-1:0]     excpc_val,
  input  logic [DW-1:0]     maclo_val,
  input  logic [DW-1:0]     machi_val,
  output logic [DW-1:0]     wr_data,
  output logic              we_fpu,
  output logic              we_excpc,
  output logic              we_excstat,
  output logic              we_maclo,
  output logic              we_machi,
  output logic              we_status,
  output logic [DW-1:0]     status_wval,
  output logic              pc_redirect,
  output logic [DW-1:0]     redirect_pc,
  output logic              clear_delay,
  output logic              warn,
  output logic [ADDR_W-1:0] warn_addr,
  output logic [1:0]        warn_code
);

  localparam int unsigned IDX_W = (WIN_DEPTH > 1) ? $clog2(WIN_DEPTH) : 1;

  reg_id_e          id;
  logic [IDX_W-1:0] win_idx;
  logic [DW-1:0]    win_rdata;
  logic [DW-1:0]    named_rd;
  logic             priv_ok;
  logic             rd_go;
  logic             wr_go;
  logic             win_we;
  warn_code_e       code_now;

  sprg_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_DEPTH(WIN_DEPTH),
    .REG_COUNT(REG_COUNT), .IDX_W(IDX_W)
  ) u_dec (
    .addr(req_addr), .id(id), .win_idx(win_idx)
  );

  sprg_window #(.DW(DW), .DEPTH(WIN_DEPTH), .IDX_W(IDX_W)) u_win (
    .clk(clk), .rst_n(rst_n), .wr_en(win_we), .idx(win_idx),
    .wr_data(req_wdata), .rd_data(win_rdata)
  );

  sprg_warn #(.ADDR_W(ADDR_W)) u_warn (
    .clk(clk), .rst_n(rst_n), .code_in(code_now), .addr_in(req_addr),
    .warn(warn), .warn_addr(warn_addr), .warn_code(warn_code)
  );

  assign req_ready = 1'b1;
  assign priv_ok   = sup_mode | user_sr_rd;
  assign rd_go     = req_valid & ~req_write & priv_ok & id_readable(id);
  assign wr_go     = req_valid &  req_write & priv_ok & id_writable(id);

  always_comb begin
    case (id)
      ID_VER:    named_rd = ver_val;
      ID_UNIT:   named_rd = unit_val;
      ID_CFG:    named_rd = cfg_val;
      ID_STAT:   named_rd = stat_val;
      ID_PREVPC: named_rd = prevpc_val;
      ID_FPU:    named_rd = fpu_val;
      ID_EXCPC:  named_rd = excpc_val;
      ID_MACLO:  named_rd = maclo_val;
      ID_MACHI:  named_rd = machi_val;
      ID_WIN:    named_rd = win_rdata;
      default:   named_rd = '0;
    endcase
  end

  assign rd_data = rd_go ? named_rd : '0;

  // write enables and side-effect strobes
  assign wr_data     = req_wdata;
  assign we_fpu      = wr_go && (id == ID_FPU);
  assign we_excpc    = wr_go && (id == ID_EXCPC);
  assign we_excstat  = wr_go && (id == ID_EXCSTAT);
  assign we_maclo    = wr_go && (id == ID_MACLO);
  assign we_machi    = wr_go && (id == ID_MACHI);
  assign we_status   = wr_go && (id == ID_STAT);
  assign win_we      = wr_go && (id == ID_WIN);
  assign pc_redirect = wr_go && (id == ID_NEXTPC);
  assign clear_delay = pc_redirect;
  assign redirect_pc = req_wdata;
  assign status_wval = req_wdata | (DW'(1) << FO_BIT);

  always_comb begin
    code_now = WC_NONE;
    if (req_valid) begin
      if (!priv_ok)
        code_now = WC_PRIV;
      else if (req_write ? !id_writable(id) : !id_readable(id))
        code_now = WC_ADDR;
      else if (req_write && (id == ID_TMODE) && (req_wdata != '0))
        code_now = WC_VALUE;
    end
  end

  AST_DENY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sup_mode && !user_sr_rd) |->
      (rd_data == '0 && !win_we && !we_status && !pc_redirect && !we_fpu)) // R1
    else $error("privilege gate leaked");

  AST_DENY_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sup_mode && !user_sr_rd) |=> (warn && warn_code == 2'd1)) // R1
    else $error("privilege warning missing");

  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && 32'(req_addr) >= REG_COUNT) |-> (rd_data == '0)) // R2
    else $error("out-of-range read returned data");

  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_fpu, we_excpc, we_excstat, we_maclo, we_machi,
              we_status, pc_redirect, win_we})) // R4
    else $error("several enables at once");

  AST_FIXED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    we_status |-> status_wval[FO_BIT]) // R6
    else $error("fixed-one bit not forced");

  AST_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    pc_redirect |-> (clear_delay && redirect_pc == req_wdata)) // R7
    else $error("redirect malformed");

  AST_TMODE_NOSTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && 32'(req_addr) == A_TMODE && req_wdata != '0) |->
      !$countones({we_fpu, we_excpc, we_excstat, we_maclo, we_machi,
                   we_status, pc_redirect, win_we})) // R8
    else $error("timer mode write stored");

endmodule

// File: tb/sim_spr_access_gate.sv
`timescale 1ns/100ps
module sim_spr_access_gate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        sup_mode = 1'b0, user_sr_rd = 1'b0;
  logic        req_ready;
  logic [31:0] rd_data, wr_data, status_wval, redirect_pc;
  logic        we_fpu, we_excpc, we_excstat, we_maclo, we_machi, we_status;
  logic        pc_redirect, clear_delay, warn;
  logic [16:0] warn_addr;
  logic [1:0]  warn_code;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spr_access_gate u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .sup_mode(sup_mode), .user_sr_rd(user_sr_rd), .rd_data(rd_data),
    .ver_val(32'hA500_0001), .unit_val(32'h0000_0011), .cfg_val(32'h0000_0022),
    .stat_val(32'h0000_0033), .prevpc_val(32'h0000_0044), .fpu_val(32'h0000_0055),
    .excpc_val(32'h0000_0066), .maclo_val(32'h0000_0077), .machi_val(32'h0000_0088),
    .wr_data(wr_data), .we_fpu(we_fpu), .we_excpc(we_excpc),
    .we_excstat(we_excstat), .we_maclo(we_maclo), .we_machi(we_machi),
    .we_status(we_status), .status_wval(status_wval), .pc_redirect(pc_redirect),
    .redirect_pc(redirect_pc), .clear_delay(clear_delay), .warn(warn),
    .warn_addr(warn_addr), .warn_code(warn_code)
  );

  // {req, sup, usr, write, addr, wdata, exp_rd, exp_we{redir,stat,mhi,mlo,estat,epc,fpu}, exp_code}
  localparam int NV = 22;
  localparam logic [96:0] VEC [NV] = '{
    {4'd3,  3'b100, 17'h00000, 32'h0,        32'hA500_0001, 7'b0000000, 2'd0}, // R3
    {4'd11, 3'b010, 17'h02802, 32'h0,        32'h0000_0088, 7'b0000000, 2'd0}, // R11
    {4'd3,  3'b100, 17'h00040, 32'h0,        32'h0,         7'b0000000, 2'd2}, // R3
    {4'd4,  3'b101, 17'h00014, 32'h1234,     32'h0,         7'b0000001, 2'd0}, // R4
    {4'd4,  3'b101, 17'h02801, 32'h99,       32'h0,         7'b0001000, 2'd0}, // R4
    {4'd4,  3'b101, 17'h00012, 32'h5,        32'h0,         7'b0000000, 2'd2}, // R4
    {4'd6,  3'b101, 17'h00011, 32'h0,        32'h0,         7'b0100000, 2'd0}, // R6
    {4'd7,  3'b101, 17'h00010, 32'h2000,     32'h0,         7'b1000000, 2'd0}, // R7
    {4'd8,  3'b101, 17'h05000, 32'h0,        32'h0,         7'b0000000, 2'd0}, // R8
    {4'd8,  3'b101, 17'h05000, 32'h5,        32'h0,         7'b0000000, 2'd3}, // R8
    {4'd5,  3'b101, 17'h00405, 32'hDEADBEEF, 32'h0,         7'b0000000, 2'd0}, // R5
    {4'd5,  3'b100, 17'h00405, 32'h0,        32'hDEADBEEF,  7'b0000000, 2'd0}, // R5
    {4'd1,  3'b001, 17'h00405, 32'h1,        32'h0,         7'b0000000, 2'd1}, // R1
    {4'd1,  3'b100, 17'h00405, 32'h0,        32'hDEADBEEF,  7'b0000000, 2'd0}, // R1
    {4'd2,  3'b100, 17'h10000, 32'h0,        32'h0,         7'b0000000, 2'd2}, // R2
    {4'd2,  3'b101, 17'h1FFFF, 32'h3,        32'h0,         7'b0000000, 2'd2}, // R2
    {4'd2,  3'b100, 17'h00600, 32'h0,        32'h0,         7'b0000000, 2'd2}, // R2
    {4'd11, 3'b011, 17'h00406, 32'h77,       32'h0,         7'b0000000, 2'd0}, // R11
    {4'd11, 3'b010, 17'h00406, 32'h0,        32'h77,        7'b0000000, 2'd0}, // R11
    {4'd1,  3'b000, 17'h00000, 32'h0,        32'h0,         7'b0000000, 2'd1}, // R1
    {4'd3,  3'b100, 17'h00012, 32'h0,        32'h0000_0044, 7'b0000000, 2'd0}, // R3
    {4'd4,  3'b101, 17'h00040, 32'h8,        32'h0,         7'b0000100, 2'd0}  // R4
  };

  task automatic chk(input bit ok, input int rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input bit v, input bit s, input bit u, input bit w,
                       input logic [16:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = v; sup_mode = s; user_sr_rd = u; req_write = w;
    req_addr = a; req_wdata = d;
    #1;
  endtask

  function automatic logic [6:0] we_vec();
    return {pc_redirect, we_status, we_machi, we_maclo, we_excstat, we_excpc, we_fpu};
  endfunction

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R9 watchdog expired: actual %h expected %h", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(warn == 1'b0, 10, "warn during reset", 32'(warn), 0);
    rst_n = 1'b1;
    // R10: window cleared by reset
    drive(1, 1, 0, 0, 17'h005FF, 0);
    chk(rd_data == 0, 10, "window after reset", rd_data, 0);
    chk(req_ready == 1'b1, 9, "ready", 32'(req_ready), 1);
    @(posedge clk); #1;
    chk(warn == 1'b0, 10, "warn after reset", 32'(warn), 0);

    for (int i = 0; i < NV; i++) begin
      logic [96:0] v;
      int rq;
      v  = VEC[i];
      rq = int'(v[96:93]);
      drive(1, v[92], v[91], v[90], v[89:73], v[72:41]);
      chk(rd_data == v[40:9], rq, $sformatf("vec%0d rd_data", i), rd_data, v[40:9]);
      chk(we_vec() == v[8:2], rq, $sformatf("vec%0d enables", i), 32'(we_vec()), 32'(v[8:2]));
      if (v[90] && v[8:2] != 0)
        chk(wr_data == v[72:41], rq, $sformatf("vec%0d wr_data", i), wr_data, v[72:41]);
      @(posedge clk); #1;
      chk(warn_code == v[1:0] && warn == (v[1:0] != 0), rq,
          $sformatf("vec%0d warn code", i), 32'(warn_code), 32'(v[1:0]));
      if (v[1:0] != 0)
        chk(warn_addr == v[89:73], rq, $sformatf("vec%0d warn_addr", i),
            32'(warn_addr), 32'(v[89:73]));
    end

    // R6: fixed-one bit forced
    drive(1, 1, 0, 1, 17'h00011, 32'h0000_00F0);
    chk(status_wval == 32'h0000_80F0, 6, "status_wval", status_wval, 32'h0000_80F0);
    // R7: redirect target and delay clear
    drive(1, 1, 0, 1, 17'h00010, 32'h0000_3000);
    chk(pc_redirect && clear_delay && redirect_pc == 32'h3000, 7, "redirect",
        redirect_pc, 32'h3000);
    // R9: invalid request, then idle; warning lasts one cycle
    drive(1, 1, 0, 0, 17'h00050, 0);
    @(posedge clk); #1;
    chk(warn == 1'b1, 9, "warn pulse high", 32'(warn), 1);
    drive(0, 1, 0, 1, 17'h00407, 32'h7);
    chk(we_vec() == 0, 9, "valid low enables", 32'(we_vec()), 0);
    @(posedge clk); #1;
    chk(warn == 1'b0, 9, "warn pulse single", 32'(warn), 0);
    drive(1, 1, 0, 0, 17'h00407, 0);
    chk(rd_data == 0, 9, "valid low no store", rd_data, 0);
    @(posedge clk); #1;

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule